// File: doc/BRIEF.md
# Line-Split Dual-Engine Blit Dispatcher

This block takes one rectangular blit and divides it by lines between two copy engines that run side by side. The upper part of the rectangle goes to an engine that moves 16-bit words. The lower part goes to an engine that moves 32-bit longwords. The line where the rectangle is cut is not computed at run time. It is read from a small table that software fills in advance, one entry per object size class.

On an accepted start, the dispatcher does the following in one cycle:
- it works out the start address, line count and per-line transfer count for each half;
- it pulses a launch strobe to each engine that has lines to do;
- it waits until every launched engine reports completion, then raises a done flag.

The done flag stays high until the next accepted start. A half with zero lines is never launched.

Top module: `split_dispatch`

## Requirements
- R1: After reset, both launch strobes, `busy` and `done` are low, all command outputs are zero, and every table entry is zero.
- R2: On an accepted start, the word engine gets `w_addr` = `base_addr` and `w_lines` = min(table entry of `size_class`, `height`).
- R3: The longword engine gets `l_lines` = `height` − `w_lines` and `l_addr` = `base_addr` + `w_lines` × `stride`, modulo 2^AW. `stride` is the full row pitch in bytes, modulo included.
- R4: `w_words` = ceil(`width_px` / 16) + 1. The extra word is shift space, so 32 pixels gives 3.
- R5: `l_longs` = ceil((`width_px` + 16) / 32). This is object plus shift space, rounded up to a multiple of 32 pixels, so 32 pixels gives 2.
- R6: A table entry of 0 launches only the longword engine. An entry greater than or equal to `height` launches only the word engine. A half with zero lines gets no strobe.
- R7: A start with `busy` low is accepted at a clock edge. Each strobe needed is then high for exactly the one following cycle, and both strobes rise in the same cycle.
- R8: `done` rises one cycle after the last pending engine reports, and not earlier. It stays high until the clock edge that accepts the next start, which clears it. `busy` is high from acceptance until `done` rises.
- R9: A start while `busy` is high is ignored. No strobe is issued and the command outputs keep their values.
- R10: A table write (`tbl_we`, `tbl_idx`, `tbl_lines`) takes effect at the clock edge. A start in the same cycle as a write uses the entry's previous contents.
- R11: A completion pulse from an engine that is not pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to dispatch the descriptor |
| base_addr | input | AW | Byte address of the first line |
| stride | input | AW | Bytes from one line to the next |
| height | input | HW | Total lines |
| width_px | input | PXW | Object width in pixels, without shift space |
| size_class | input | CW | Table index for this object |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | CW | Table entry written |
| tbl_lines | input | HW | Split line count written |
| w_go | output | 1 | Word engine launch strobe |
| w_addr | output | AW | Word engine start address |
| w_lines | output | HW | Word engine line count |
| w_words | output | CNTW | Words per line for the word engine |
| w_done | input | 1 | Word engine completion pulse |
| l_go | output | 1 | Longword engine launch strobe |
| l_addr | output | AW | Longword engine start address |
| l_lines | output | HW | Longword engine line count |
| l_longs | output | CNTW | Longwords per line for the longword engine |
| l_done | input | 1 | Longword engine completion pulse |
| busy | output | 1 | A dispatch is outstanding |
| done | output | 1 | Both halves finished |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a table write and a start that reads the same entry. The bench drives both in one cycle and expects the cut from the old entry. A second start then must show the new entry.

The second pair is the two completion pulses, which the bench drives in one cycle. It then expects `done` exactly one edge later. It also staggers the two pulses to confirm that `done` waits for the later one. A behavioural model updated on every edge judges all outputs each cycle.

// File: rtl/split_dispatch.sv
module split_dispatch #(
  parameter int AW   = 24,
  parameter int HW   = 10,
  parameter int PXW  = 10,
  parameter int CNTW = 7,
  parameter int NCLS = 8,
  localparam int CW  = $clog2(NCLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   stride,
  input  logic [HW-1:0]   height,
  input  logic [PXW-1:0]  width_px,
  input  logic [CW-1:0]   size_class,
  input  logic            tbl_we,
  input  logic [CW-1:0]   tbl_idx,
  input  logic [HW-1:0]   tbl_lines,
  output logic            w_go,
  output logic [AW-1:0]   w_addr,
  output logic [HW-1:0]   w_lines,
  output logic [CNTW-1:0] w_words,
  input  logic            w_done,
  output logic            l_go,
  output logic [AW-1:0]   l_addr,
  output logic [HW-1:0]   l_lines,
  output logic [CNTW-1:0] l_longs,
  input  logic            l_done,
  output logic            busy,
  output logic            done
);

  localparam int PW = AW + HW;

  logic [HW-1:0]  cut_tbl [NCLS];
  logic           pend_w, pend_l;
  logic [HW-1:0]  entry, top_n, bot_n;
  logic [PW-1:0]  offs;
  logic [PXW:0]   wsum;
  logic [PXW+1:0] lsum;
  logic           accept, pw_nx, pl_nx;

  assign entry  = cut_tbl[size_class];
  assign top_n  = (entry >= height) ? height : entry;
  assign bot_n  = height - top_n;
  assign offs   = PW'(top_n) * PW'(stride);
  assign wsum   = {1'b0, width_px} + (PXW+1)'(15);
  assign lsum   = {2'b00, width_px} + (PXW+2)'(47);
  assign accept = start & ~busy;
  assign pw_nx  = pend_w & ~w_done;
  assign pl_nx  = pend_l & ~l_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCLS; i++) cut_tbl[i] <= '0;
      pend_w <= 1'b0; pend_l <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      w_go <= 1'b0; l_go <= 1'b0;
      w_addr <= '0; w_lines <= '0; w_words <= '0;
      l_addr <= '0; l_lines <= '0; l_longs <= '0;
    end else begin
      w_go <= 1'b0;
      l_go <= 1'b0;
      if (tbl_we) cut_tbl[tbl_idx] <= tbl_lines;
      if (accept) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        pend_w  <= (top_n != '0);
        pend_l  <= (bot_n != '0);
        w_go    <= (top_n != '0);
        l_go    <= (bot_n != '0);
        w_addr  <= base_addr;
        w_lines <= top_n;
        w_words <= CNTW'(wsum >> 4) + CNTW'(1);
        l_addr  <= base_addr + offs[AW-1:0];
        l_lines <= bot_n;
        l_longs <= CNTW'(lsum >> 5);
      end else if (busy) begin
        pend_w <= pw_nx;
        pend_l <= pl_nx;
        if (!pw_nx && !pl_nx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R7
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_go || l_go) |=> (!w_go && !l_go));
  // R7
  go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_go || l_go) |-> $past(start && !busy));
  // R6
  no_empty_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_go |-> w_lines != '0) and (l_go |-> l_lines != '0));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!w_go && !l_go && $stable(w_addr) && $stable(l_addr)));
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

endmodule

// File: tb/tb_split_dispatch.sv
module tb_split_dispatch;
  localparam int AW = 24, HW = 10, PXW = 10, CNTW = 7, NCLS = 8, CW = 3;

  logic clk = 0, rst_n = 0;
  logic start = 0, tbl_we = 0, w_done = 0, l_done = 0;
  logic [AW-1:0] base_addr = '0, stride = '0;
  logic [HW-1:0] height = '0, tbl_lines = '0;
  logic [PXW-1:0] width_px = '0;
  logic [CW-1:0] size_class = '0, tbl_idx = '0;
  logic w_go, l_go, busy, done;
  logic [AW-1:0] w_addr, l_addr;
  logic [HW-1:0] w_lines, l_lines;
  logic [CNTW-1:0] w_words, l_longs;

  split_dispatch dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_tbl [NCLS];
  bit m_busy, m_done, m_pw, m_pl, m_wgo, m_lgo;
  longint m_waddr, m_wlines, m_wwords, m_laddr, m_llines, m_llongs;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_tbl[i]) m_tbl[i] = 0;
      m_busy = 0; m_done = 0; m_pw = 0; m_pl = 0; m_wgo = 0; m_lgo = 0;
      m_waddr = 0; m_wlines = 0; m_wwords = 0; m_laddr = 0; m_llines = 0; m_llongs = 0;
    end else begin
      m_wgo = 0; m_lgo = 0;
      if (start && !m_busy) begin
        longint t, b;
        t = (m_tbl[size_class] >= height) ? height : m_tbl[size_class];
        b = height - t;
        m_busy = 1; m_done = 0;
        m_pw = (t != 0); m_pl = (b != 0);
        m_wgo = m_pw; m_lgo = m_pl;
        m_waddr = base_addr; m_wlines = t;
        m_wwords = (width_px + 15) / 16 + 1;
        m_laddr = (longint'(base_addr) + t * longint'(stride)) % (longint'(1) << AW);
        m_llines = b;
        m_llongs = (width_px + 16 + 31) / 32;
      end else if (m_busy) begin
        if (w_done) m_pw = 0;
        if (l_done) m_pl = 0;
        if (!m_pw && !m_pl) begin m_busy = 0; m_done = 1; end
      end
      if (tbl_we) m_tbl[tbl_idx] = tbl_lines;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(w_go == m_wgo, "R7 w_go", w_go, m_wgo);
    chk(l_go == m_lgo, "R7 l_go", l_go, m_lgo);
    chk(w_addr == m_waddr, "R2 w_addr", w_addr, m_waddr);
    chk(w_lines == m_wlines, "R2 w_lines", w_lines, m_wlines);
    chk(l_addr == m_laddr, "R3 l_addr", l_addr, m_laddr);
    chk(l_lines == m_llines, "R3 l_lines", l_lines, m_llines);
    chk(w_words == m_wwords, "R4 w_words", w_words, m_wwords);
    chk(l_longs == m_llongs, "R5 l_longs", l_longs, m_llongs);
    chk(busy == m_busy, "R8 busy", busy, m_busy);
    chk(done == m_done, "R8 done", done, m_done);
  end

  bit s_wgo, s_lgo;
  task automatic launch(input int b, input int s, input int h, input int w, input int c);
    @(negedge clk); #2;
    base_addr = AW'(b); stride = AW'(s); height = HW'(h); width_px = PXW'(w);
    size_class = CW'(c); start = 1;
    @(negedge clk);
    s_wgo = w_go; s_lgo = l_go;
    #2 start = 0;
  endtask

  task automatic wr_tbl(input int i, input int v);
    @(negedge clk); #2; tbl_we = 1; tbl_idx = CW'(i); tbl_lines = HW'(v);
    @(negedge clk); #2; tbl_we = 0;
  endtask

  task automatic pulse(input bit wd, input bit ld);
    @(negedge clk); #2; w_done = wd; l_done = ld;
    @(negedge clk); #2; w_done = 0; l_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!w_go && !l_go && !busy && !done, "R1 ctrl", {w_go, l_go, busy, done}, 0);
    chk(w_addr == 0 && l_addr == 0 && w_lines == 0, "R1 cmd", w_addr, 0);
    #2 rst_n = 1;
    // R1 table zero: whole blit to longword engine (R6)
    launch(32'h200, 8, 5, 16, 5);
    chk(s_wgo == 0 && s_lgo == 1, "R1 R6 entry0", {s_wgo, s_lgo}, 1);
    pulse(0, 1);
    @(negedge clk); chk(done == 1, "R8 done after l", done, 1);
    wr_tbl(1, 4); wr_tbl(2, 10); wr_tbl(3, 100);
    // normal split
    launch(32'h1000, 40, 16, 32, 1);
    chk(s_wgo && s_lgo, "R7 both go", {s_wgo, s_lgo}, 3);
    chk(done == 0, "R8 clear on start", done, 0);
    chk(l_addr == 32'h10A0, "R3 addr", l_addr, 32'h10A0);
    chk(w_words == 3 && l_longs == 2, "R4 R5 32px", {w_words, l_longs}, {7'd3, 7'd2});
    // R9 ignored start while busy
    launch(32'h5000, 4, 7, 64, 3);
    chk(s_wgo == 0 && s_lgo == 0, "R9 no go", {s_wgo, s_lgo}, 0);
    chk(w_addr == 32'h1000, "R9 hold", w_addr, 32'h1000);
    pulse(1, 0);
    @(negedge clk); chk(done == 0, "R8 wait second", done, 0);
    pulse(0, 1);
    @(negedge clk); chk(done == 1, "R8 done", done, 1);
    // entry equal to height: word engine only
    launch(32'h3000, 20, 10, 16, 2);
    chk(s_wgo == 1 && s_lgo == 0, "R6 entry==h", {s_wgo, s_lgo}, 2);
    chk(w_words == 2 && l_longs == 1, "R4 R5 16px", {w_words, l_longs}, {7'd2, 7'd1});
    pulse(0, 1);  // R11 stray longword completion
    @(negedge clk); chk(busy == 1 && done == 0, "R11 stray", {busy, done}, 2);
    pulse(1, 0);
    // entry above height, wide object
    launch(32'h4000, 64, 30, 100, 3);
    chk(s_wgo == 1 && s_lgo == 0, "R6 entry>h", {s_wgo, s_lgo}, 2);
    chk(w_lines == 30 && w_words == 8 && l_longs == 4, "R2 R4 R5 wide", w_lines, 30);
    pulse(1, 0);
    // R10 write and start in the same cycle
    @(negedge clk); #2;
    tbl_we = 1; tbl_idx = 1; tbl_lines = 6;
    base_addr = 24'h8000; stride = 100; height = 9; width_px = 48; size_class = 1; start = 1;
    @(negedge clk); #2; tbl_we = 0; start = 0;
    chk(w_lines == 4 && l_lines == 5, "R10 old entry", w_lines, 4);
    pulse(1, 1);  // both complete together
    @(negedge clk); chk(done == 1, "R8 joint done", done, 1);
    launch(32'h8000, 100, 9, 48, 1);
    chk(w_lines == 6 && l_addr == 32'h8000 + 600, "R10 new entry", w_lines, 6);
    pulse(1, 1);
    // height zero: nothing launched
    launch(32'h0, 4, 0, 8, 2);
    chk(s_wgo == 0 && s_lgo == 0, "R6 empty", {s_wgo, s_lgo}, 0);
    @(negedge clk); chk(done == 1, "R8 empty done", done, 1);
    // address wrap
    launch(32'hFFFFF0, 32'h10, 8, 8, 1);
    chk(l_addr == 24'h000050, "R3 wrap", l_addr, 24'h50);
    pulse(1, 1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog: act=hung exp=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule